// File: doc/BRIEF.md
# Trace-Level Global Register Renamer

This block renames one whole trace per accepted request into the global physical register space. Each trace arrives already renamed internally, so it carries only two masks over the logical registers. One mask marks the values the trace reads from earlier traces. The other marks the values it leaves behind for later traces. The renamer reads the current global map for every marked input. It takes one fresh physical register from a bitmap free list for every marked output. Then it rewrites the map entries of those outputs. No dependence check is done between instructions inside the trace.

Every accepted trace claims a checkpoint slot. The slot holds the map and the free-list bitmap as they stood just before that trace was renamed. When all branches of the trace resolve correctly, the slot is released. On a misprediction, the map and the free list are rolled back from the slot of that trace. On an exception, the map is reloaded from an architectural map supplied at the ports, and the free list is rebuilt from it. Results appear one cycle after acceptance.

Top module: `trn_global_rename`

## Requirements
- R1: After reset the map sends logical register i to physical register i. Physical registers 8 to 63 are free, all four checkpoint slots are free, `out_valid` is 0 and `ren_ready` is 1.
- R2: For each bit i set in `ren_livein_mask`, lane i of `out_livein_map` holds the map entry of register i as it stood before this trace. This holds even when bit i is also set in the live-out mask. Lanes not in the mask are 0. Lane i occupies bits [6i+5:6i].
- R3: Live-out registers receive the lowest-numbered free physical registers, handed out in ascending logical-register order. Lane i of `out_liveout_new` holds the new register and lane i of `out_liveout_prev` holds the replaced one. Non-live-out lanes are 0, and the map takes the new entries.
- R4: `ren_ready` is 0 while fewer physical registers are free than bits set in `ren_liveout_mask`. A request offered then changes nothing. A trace that needs exactly the number of free registers is accepted.
- R5: Each accepted trace takes the lowest-numbered free checkpoint slot, reported on `out_ckpt_id`. With all four slots held, `ren_ready` is 0. Asserting `resolve_valid` for a slot frees it.
- R6: `mispredict_valid` for slot k restores the map and the free list to their state just before the trace of slot k was renamed. It frees slot k and every slot taken after it.
- R7: `exception_valid` loads the map from `arch_map_flat`, which uses the same lane layout. It marks free every physical register not named in that input and frees all checkpoint slots. It takes priority over a misprediction in the same cycle.
- R8: `out_valid` is 1 in exactly the cycle after an accepted request. `ren_ready` is 0 in any cycle with a restore, so a request in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Trace rename request |
| ren_ready | output | 1 | Request can be accepted this cycle |
| ren_livein_mask | input | 8 | Logical registers read from earlier traces |
| ren_liveout_mask | input | 8 | Logical registers written for later traces |
| resolve_valid | input | 1 | All branches of a trace resolved correctly |
| resolve_ckpt | input | 2 | Slot to release |
| mispredict_valid | input | 1 | Branch misprediction inside a trace |
| mispredict_ckpt | input | 2 | Slot of the mispredicted trace |
| exception_valid | input | 1 | Exception restore request |
| arch_map_flat | input | 48 | Architectural map, 6 bits per logical register |
| out_valid | output | 1 | Rename result valid |
| out_ckpt_id | output | 2 | Slot claimed by the renamed trace |
| out_livein_map | output | 48 | Physical registers of live-ins |
| out_liveout_new | output | 48 | Newly allocated physical registers of live-outs |
| out_liveout_prev | output | 48 | Replaced physical registers of live-outs |

## Verification
The checker assumes that resolve and misprediction requests name slots that are currently held. It also assumes that the architectural map names eight distinct physical registers. The bench keeps within these limits by tracking which slots are live and resolving or mispredicting only those. Its exception restore uses a permutation of distinct registers. The stimulus sweeps mask patterns from empty to full. It walks the free list down to exactly zero and fills every checkpoint slot, so the stall conditions are reached at their exact boundaries.

// File: rtl/trn_pkg.sv
package trn_pkg;
    localparam int TRN_NUM_LREG = 8;
    localparam int TRN_NUM_PREG = 64;
    localparam int TRN_NUM_CKPT = 4;

    typedef enum logic [1:0] {
        RST_NONE   = 2'd0,
        RST_BRANCH = 2'd1,
        RST_EXCEPT = 2'd2
    } restore_e;

    function automatic restore_e pick_restore(input logic exc, input logic misp);
        if (exc)       return RST_EXCEPT;
        else if (misp) return RST_BRANCH;
        else           return RST_NONE;
    endfunction
endpackage

// File: rtl/trn_freelist.sv
module trn_freelist #(
    parameter int NUM_LREG = 8,
    parameter int NUM_PREG = 64,
    parameter int PREG_W   = $clog2(NUM_PREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_LREG-1:0]        want_mask,
    input  logic                       alloc_en,
    input  logic                       load_en,
    input  logic [NUM_PREG-1:0]        load_bits,
    output logic [NUM_LREG*PREG_W-1:0] picks,
    output logic                       enough,
    output logic [NUM_PREG-1:0]        free_bits
);
    logic [NUM_PREG-1:0] free_q;
    logic [NUM_PREG-1:0] remain;

    always_comb begin
        logic found;
        remain = free_q;
        picks  = '0;
        for (int i = 0; i < NUM_LREG; i++) begin
            found = 1'b0;
            if (want_mask[i]) begin
                for (int p = 0; p < NUM_PREG; p++) begin
                    if (!found && remain[p]) begin
                        picks[i*PREG_W +: PREG_W] = PREG_W'(p);
                        remain[p] = 1'b0;
                        found = 1'b1;
                    end
                end
            end
        end
    end

    assign enough    = $countones(free_q) >= $countones(want_mask);
    assign free_bits = free_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_PREG; p++)
                free_q[p] <= (p >= NUM_LREG);
        end else if (load_en) begin
            free_q <= load_bits;
        end else if (alloc_en) begin
            free_q <= remain;
        end
    end
endmodule

// File: rtl/trn_ckpt_ctrl.sv
module trn_ckpt_ctrl #(
    parameter int NUM_CKPT = 4,
    parameter int CKPT_W   = $clog2(NUM_CKPT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc_en,
    input  logic                release_en,
    input  logic [CKPT_W-1:0]   release_id,
    input  logic                rollback_en,
    input  logic [CKPT_W-1:0]   rollback_id,
    input  logic                flush_all,
    output logic                slot_avail,
    output logic [CKPT_W-1:0]   alloc_id,
    output logic [NUM_CKPT-1:0] slot_valid
);
    logic [NUM_CKPT-1:0] valid_q;
    // younger_q[j][k] set: slot k was claimed after slot j
    logic [NUM_CKPT-1:0] younger_q [NUM_CKPT];
    logic [NUM_CKPT-1:0] kill_mask;

    always_comb begin
        alloc_id = '0;
        for (int s = NUM_CKPT - 1; s >= 0; s--)
            if (!valid_q[s]) alloc_id = CKPT_W'(s);
    end

    assign slot_avail = ~&valid_q;
    assign slot_valid = valid_q;

    always_comb begin
        kill_mask = younger_q[rollback_id];
        kill_mask[rollback_id] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int j = 0; j < NUM_CKPT; j++) younger_q[j] <= '0;
        end else if (flush_all) begin
            valid_q <= '0;
        end else if (rollback_en) begin
            valid_q <= valid_q & ~kill_mask;
        end else begin
            if (alloc_en) begin
                for (int j = 0; j < NUM_CKPT; j++)
                    if (valid_q[j]) younger_q[j][alloc_id] <= 1'b1;
                younger_q[alloc_id] <= '0;
            end
            for (int s = 0; s < NUM_CKPT; s++) begin
                if (alloc_en && alloc_id == CKPT_W'(s))
                    valid_q[s] <= 1'b1;
                else if (release_en && release_id == CKPT_W'(s))
                    valid_q[s] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/trn_shadow_store.sv
module trn_shadow_store #(
    parameter int NUM_CKPT = 4,
    parameter int NUM_LREG = 8,
    parameter int NUM_PREG = 64,
    parameter int PREG_W   = $clog2(NUM_PREG),
    parameter int CKPT_W   = $clog2(NUM_CKPT)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [CKPT_W-1:0]          wr_id,
    input  logic [NUM_LREG*PREG_W-1:0] wr_map,
    input  logic [NUM_PREG-1:0]        wr_free,
    input  logic [CKPT_W-1:0]          rd_id,
    output logic [NUM_LREG*PREG_W-1:0] rd_map,
    output logic [NUM_PREG-1:0]        rd_free
);
    logic [NUM_LREG*PREG_W-1:0] map_slot  [NUM_CKPT];
    logic [NUM_PREG-1:0]        free_slot [NUM_CKPT];

    for (genvar s = 0; s < NUM_CKPT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                map_slot[s]  <= '0;
                free_slot[s] <= '0;
            end else if (wr_en && wr_id == CKPT_W'(s)) begin
                map_slot[s]  <= wr_map;
                free_slot[s] <= wr_free;
            end
        end
    end

    assign rd_map  = map_slot[rd_id];
    assign rd_free = free_slot[rd_id];
endmodule

// File: rtl/trn_global_rename.sv
module trn_global_rename
    import trn_pkg::*;
#(
    parameter int NUM_LREG = TRN_NUM_LREG,
    parameter int NUM_PREG = TRN_NUM_PREG,
    parameter int NUM_CKPT = TRN_NUM_CKPT,
    localparam int PREG_W  = $clog2(NUM_PREG),
    localparam int CKPT_W  = $clog2(NUM_CKPT),
    localparam int MAP_W   = NUM_LREG * PREG_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ren_valid,
    output logic                ren_ready,
    input  logic [NUM_LREG-1:0] ren_livein_mask,
    input  logic [NUM_LREG-1:0] ren_liveout_mask,
    input  logic                resolve_valid,
    input  logic [CKPT_W-1:0]   resolve_ckpt,
    input  logic                mispredict_valid,
    input  logic [CKPT_W-1:0]   mispredict_ckpt,
    input  logic                exception_valid,
    input  logic [MAP_W-1:0]    arch_map_flat,
    output logic                out_valid,
    output logic [CKPT_W-1:0]   out_ckpt_id,
    output logic [MAP_W-1:0]    out_livein_map,
    output logic [MAP_W-1:0]    out_liveout_new,
    output logic [MAP_W-1:0]    out_liveout_prev
);
    logic [MAP_W-1:0]    map_q;
    logic [MAP_W-1:0]    picks;
    logic [NUM_PREG-1:0] fl_free_bits;
    logic [NUM_PREG-1:0] fl_load_bits;
    logic [NUM_PREG-1:0] arch_used;
    logic [MAP_W-1:0]    sh_map;
    logic [NUM_PREG-1:0] sh_free;
    logic [NUM_CKPT-1:0] ck_valid;
    logic [CKPT_W-1:0]   ck_alloc_id;
    logic                ck_avail;
    logic                fl_enough;
    logic                accept;
    restore_e            restore;

    assign restore   = pick_restore(exception_valid, mispredict_valid);
    assign ren_ready = fl_enough && ck_avail && (restore == RST_NONE);
    assign accept    = ren_valid && ren_ready;

    always_comb begin
        arch_used = '0;
        for (int i = 0; i < NUM_LREG; i++)
            arch_used[arch_map_flat[i*PREG_W +: PREG_W]] = 1'b1;
        fl_load_bits = (restore == RST_EXCEPT) ? ~arch_used : sh_free;
    end

    trn_freelist #(
        .NUM_LREG (NUM_LREG),
        .NUM_PREG (NUM_PREG)
    ) u_freelist (
        .clk       (clk),
        .rst       (rst),
        .want_mask (ren_liveout_mask),
        .alloc_en  (accept),
        .load_en   (restore != RST_NONE),
        .load_bits (fl_load_bits),
        .picks     (picks),
        .enough    (fl_enough),
        .free_bits (fl_free_bits)
    );

    trn_ckpt_ctrl #(
        .NUM_CKPT (NUM_CKPT)
    ) u_ckpt (
        .clk         (clk),
        .rst         (rst),
        .alloc_en    (accept),
        .release_en  (resolve_valid),
        .release_id  (resolve_ckpt),
        .rollback_en (restore == RST_BRANCH),
        .rollback_id (mispredict_ckpt),
        .flush_all   (restore == RST_EXCEPT),
        .slot_avail  (ck_avail),
        .alloc_id    (ck_alloc_id),
        .slot_valid  (ck_valid)
    );

    trn_shadow_store #(
        .NUM_CKPT (NUM_CKPT),
        .NUM_LREG (NUM_LREG),
        .NUM_PREG (NUM_PREG)
    ) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_id   (ck_alloc_id),
        .wr_map  (map_q),
        .wr_free (fl_free_bits),
        .rd_id   (mispredict_ckpt),
        .rd_map  (sh_map),
        .rd_free (sh_free)
    );

    // global map table
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LREG; i++)
                map_q[i*PREG_W +: PREG_W] <= PREG_W'(i);
        end else if (restore == RST_EXCEPT) begin
            map_q <= arch_map_flat;
        end else if (restore == RST_BRANCH) begin
            map_q <= sh_map;
        end else if (accept) begin
            for (int i = 0; i < NUM_LREG; i++)
                if (ren_liveout_mask[i])
                    map_q[i*PREG_W +: PREG_W] <= picks[i*PREG_W +: PREG_W];
        end
    end

    // result register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid        <= 1'b0;
            out_ckpt_id      <= '0;
            out_livein_map   <= '0;
            out_liveout_new  <= '0;
            out_liveout_prev <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_ckpt_id     <= ck_alloc_id;
                out_liveout_new <= picks;
                for (int i = 0; i < NUM_LREG; i++) begin
                    out_livein_map[i*PREG_W +: PREG_W] <=
                        ren_livein_mask[i] ? map_q[i*PREG_W +: PREG_W] : '0;
                    out_liveout_prev[i*PREG_W +: PREG_W] <=
                        ren_liveout_mask[i] ? map_q[i*PREG_W +: PREG_W] : '0;
                end
            end
        end
    end
endmodule

// File: rtl/trn_global_rename_chk.sv
module trn_global_rename_chk #(
    parameter int NUM_LREG = 8,
    parameter int NUM_PREG = 64,
    parameter int NUM_CKPT = 4,
    localparam int CKPT_W  = $clog2(NUM_CKPT)
) (
    input logic                clk,
    input logic                rst,
    input logic                ren_valid,
    input logic                ren_ready,
    input logic [NUM_LREG-1:0] ren_liveout_mask,
    input logic                mispredict_valid,
    input logic [CKPT_W-1:0]   mispredict_ckpt,
    input logic                exception_valid,
    input logic                out_valid,
    input logic [NUM_PREG-1:0] free_bits,
    input logic [NUM_CKPT-1:0] ckpt_valid,
    input logic [CKPT_W-1:0]   ckpt_alloc_id
);
    AST_OUT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_ready) |=> out_valid); // R8
    AST_NO_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(ren_valid && ren_ready) |=> !out_valid); // R8
    AST_FREE_STALL: assert property (@(posedge clk) disable iff (rst)
        ($countones(free_bits) < $countones(ren_liveout_mask)) |-> !ren_ready); // R4
    AST_CKPT_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        (&ckpt_valid) |-> !ren_ready); // R5
    AST_SLOT_CLAIMED: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_ready) |=> ckpt_valid[$past(ckpt_alloc_id)]); // R5
    AST_ROLLBACK_FREES: assert property (@(posedge clk) disable iff (rst)
        (mispredict_valid && !exception_valid) |=> !ckpt_valid[$past(mispredict_ckpt)]); // R6
    AST_EXCEPT_FLUSH: assert property (@(posedge clk) disable iff (rst)
        exception_valid |=> (ckpt_valid == '0)); // R7
endmodule

bind trn_global_rename trn_global_rename_chk #(
    .NUM_LREG (NUM_LREG),
    .NUM_PREG (NUM_PREG),
    .NUM_CKPT (NUM_CKPT)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .ren_valid        (ren_valid),
    .ren_ready        (ren_ready),
    .ren_liveout_mask (ren_liveout_mask),
    .mispredict_valid (mispredict_valid),
    .mispredict_ckpt  (mispredict_ckpt),
    .exception_valid  (exception_valid),
    .out_valid        (out_valid),
    .free_bits        (fl_free_bits),
    .ckpt_valid       (ck_valid),
    .ckpt_alloc_id    (ck_alloc_id)
);

// File: tb/trn_global_rename_tb.sv
module trn_global_rename_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;
    localparam int NP = 64;
    localparam int NC = 4;
    localparam int PW = 6;
    localparam int MW = NL * PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ren_valid = 1'b0;
    logic          ren_ready;
    logic [NL-1:0] ren_livein_mask = '0;
    logic [NL-1:0] ren_liveout_mask = '0;
    logic          resolve_valid = 1'b0;
    logic [1:0]    resolve_ckpt = '0;
    logic          mispredict_valid = 1'b0;
    logic [1:0]    mispredict_ckpt = '0;
    logic          exception_valid = 1'b0;
    logic [MW-1:0] arch_map_flat = '0;
    logic          out_valid;
    logic [1:0]    out_ckpt_id;
    logic [MW-1:0] out_livein_map;
    logic [MW-1:0] out_liveout_new;
    logic [MW-1:0] out_liveout_prev;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model
    logic [PW-1:0] m_map [NL];
    logic [NP-1:0] m_free;
    logic          m_valid [NC];
    int            m_age [NC];
    logic [PW-1:0] s_map [NC][NL];
    logic [NP-1:0] s_free [NC];
    int            m_seq = 0;
    int            last_ckpt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trn_global_rename u_dut (
        .clk              (clk),
        .rst              (rst),
        .ren_valid        (ren_valid),
        .ren_ready        (ren_ready),
        .ren_livein_mask  (ren_livein_mask),
        .ren_liveout_mask (ren_liveout_mask),
        .resolve_valid    (resolve_valid),
        .resolve_ckpt     (resolve_ckpt),
        .mispredict_valid (mispredict_valid),
        .mispredict_ckpt  (mispredict_ckpt),
        .exception_valid  (exception_valid),
        .arch_map_flat    (arch_map_flat),
        .out_valid        (out_valid),
        .out_ckpt_id      (out_ckpt_id),
        .out_livein_map   (out_livein_map),
        .out_liveout_new  (out_liveout_new),
        .out_liveout_prev (out_liveout_prev)
    );

    task automatic check(input logic ok, input string tag, input logic [MW-1:0] act,
                         input logic [MW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int free_count();
        int c = 0;
        for (int p = 0; p < NP; p++) if (m_free[p]) c++;
        return c;
    endfunction

    function automatic int low_slot();
        for (int s = 0; s < NC; s++) if (!m_valid[s]) return s;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NL; i++) m_map[i] = PW'(i);
        for (int p = 0; p < NP; p++) m_free[p] = (p >= NL);
        for (int s = 0; s < NC; s++) begin
            m_valid[s] = 1'b0;
            m_age[s] = 0;
        end
    endtask

    task automatic rename(input logic [NL-1:0] lin, input logic [NL-1:0] lout);
        logic [MW-1:0] e_in, e_new, e_prev;
        logic          e_ok;
        int            slot;
        int            need = 0;
        for (int i = 0; i < NL; i++) if (lout[i]) need++;
        slot = low_slot();
        e_ok = (free_count() >= need) && (slot >= 0);
        e_in = '0; e_new = '0; e_prev = '0;
        if (e_ok) begin
            for (int i = 0; i < NL; i++) begin
                if (lin[i]) e_in[i*PW +: PW] = m_map[i];
                if (lout[i]) begin
                    e_prev[i*PW +: PW] = m_map[i];
                    for (int p = 0; p < NP; p++) begin
                        if (m_free[p]) begin
                            e_new[i*PW +: PW] = PW'(p);
                            m_free[p] = 1'b0;
                            break;
                        end
                    end
                end
            end
        end
        @(negedge clk);
        ren_valid = 1'b1;
        ren_livein_mask = lin;
        ren_liveout_mask = lout;
        #1;
        check(ren_ready == e_ok, "R4/R5 ready", MW'(ren_ready), MW'(e_ok));
        @(negedge clk);
        ren_valid = 1'b0;
        check(out_valid == e_ok, "R8 out_valid", MW'(out_valid), MW'(e_ok));
        if (e_ok) begin
            check(out_livein_map == e_in, "R2 livein map", out_livein_map, e_in);
            check(out_liveout_new == e_new, "R3 new map", out_liveout_new, e_new);
            check(out_liveout_prev == e_prev, "R3 prev map", out_liveout_prev, e_prev);
            check(out_ckpt_id == 2'(slot), "R5 ckpt id", MW'(out_ckpt_id), MW'(slot));
            // slot saves the state before this trace; m_free already updated, so rebuild
            for (int i = 0; i < NL; i++) s_map[slot][i] = m_map[i];
            s_free[slot] = m_free;
            for (int i = 0; i < NL; i++)
                if (e_new[i*PW +: PW] != '0 || lout[i]) s_free[slot][e_new[i*PW +: PW]] = 1'b1;
            for (int i = 0; i < NL; i++) if (lout[i]) m_map[i] = e_new[i*PW +: PW];
            m_valid[slot] = 1'b1;
            m_seq++;
            m_age[slot] = m_seq;
            last_ckpt = slot;
        end
    endtask

    task automatic resolve(input int id);
        @(negedge clk);
        resolve_valid = 1'b1;
        resolve_ckpt = 2'(id);
        @(negedge clk);
        resolve_valid = 1'b0;
        m_valid[id] = 1'b0;
    endtask

    task automatic mispredict(input int id);
        @(negedge clk);
        mispredict_valid = 1'b1;
        mispredict_ckpt = 2'(id);
        ren_valid = 1'b1;
        ren_livein_mask = '1;
        ren_liveout_mask = 8'h01;
        #1;
        check(ren_ready == 1'b0, "R8 ready during rollback", MW'(ren_ready), '0);
        @(negedge clk);
        mispredict_valid = 1'b0;
        ren_valid = 1'b0;
        check(out_valid == 1'b0, "R8 request ignored in rollback", MW'(out_valid), '0);
        for (int i = 0; i < NL; i++) m_map[i] = s_map[id][i];
        m_free = s_free[id];
        for (int s = 0; s < NC; s++)
            if (s != id && m_valid[s] && m_age[s] > m_age[id]) m_valid[s] = 1'b0;
        m_valid[id] = 1'b0;
    endtask

    task automatic except(input logic [MW-1:0] arch);
        @(negedge clk);
        exception_valid = 1'b1;
        mispredict_valid = 1'b1;
        mispredict_ckpt = 2'(last_ckpt);
        arch_map_flat = arch;
        @(negedge clk);
        exception_valid = 1'b0;
        mispredict_valid = 1'b0;
        m_free = '1;
        for (int i = 0; i < NL; i++) begin
            m_map[i] = arch[i*PW +: PW];
            m_free[arch[i*PW +: PW]] = 1'b0;
        end
        for (int s = 0; s < NC; s++) m_valid[s] = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [MW-1:0] arch;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid after reset", MW'(out_valid), '0);
        check(ren_ready == 1'b1, "R1 ready after reset", MW'(ren_ready), MW'(1));
        // R1/R2 identity map seen through live-ins, R3 lowest free pops
        rename(8'hFF, 8'h05);
        // R2 register both live-in and live-out returns old mapping
        rename(8'h01, 8'h01);
        rename(8'h00, 8'hFF);
        rename(8'hAA, 8'h00);
        // R5 all slots held -> stall
        rename(8'hFF, 8'h00);
        resolve(1);
        rename(8'hFF, 8'h02);
        // R6 rollback of slot 2 frees it and the younger slots
        mispredict(2);
        rename(8'hFF, 8'h80);
        rename(8'h0F, 8'h00);
        // R4 drain the free list down to its exact boundary
        for (int k = 0; k < 6; k++) begin
            rename(8'hFF, 8'hFF);
            resolve(last_ckpt);
        end
        rename(8'hFF, 8'hFF);
        rename(8'h00, 8'h0F);
        resolve(last_ckpt);
        rename(8'hFF, 8'h01);
        rename(8'hFF, 8'h00);
        // R7 exception restore with a permuted architectural map
        for (int i = 0; i < NL; i++) arch[i*PW +: PW] = PW'(47 - i * 3);
        except(arch);
        rename(8'hFF, 8'hFF);
        rename(8'h5A, 8'hC3);
        // R6 second rollback after the exception
        mispredict(last_ckpt);
        rename(8'hFF, 8'h11);
        // sweep of mask pairs with releases
        for (int k = 0; k < 24; k++) begin
            rename(8'(k * 37 + 5), 8'(1 << (k % 8)) | 8'(k[0]));
            resolve(last_ckpt);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule